// File: doc/BRIEF.md
# Serial Clock Packet Limiter and Chip-Select Sequencer

This block sits beside the shift register of a master-mode serial port and decides, clock by clock, whether the serial clock generator may run and what level the active-low chip-select carries. The clock divider and the data shifter are outside it. The shifter reports the end of each packet with a one-cycle pulse. The host side reports whether transfers are waiting, and a small set of configuration inputs selects the behaviour.

Two functions are combined. The first is a one-shot receive limit. When a nonzero packet total is programmed, the serial clock is cut off after that many packets have completed, a sticky done flag rises, and only a software reset pulse or the hardware reset clears the count. The second is chip-select handling. In manual mode the select line copies a software level bit. In automatic mode the block lowers the select one cycle before the serial clock starts and raises it as soon as a packet ends. It then keeps the select high for a programmed gap before the next packet may begin.

Top module: `spi_pkt_cs_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `sclk_en` is 0, `cs_n` is 1 and `limit_done` is 0.
- R2: With `cfg_auto_cs` = 0, `cs_n` takes the value `cfg_manual_cs` had at the previous rising clock edge.
- R3: With `cfg_auto_cs` = 0 and the limit not reached, `sclk_en` takes the value `xfer_pending` had at the previous rising edge.
- R4: With `cfg_pkt_limit` = N > 0, the edge that samples the N-th counted `pkt_done` drives `sclk_en` to 0 and `limit_done` to 1 in the same cycle.
- R5: Once `limit_done` is 1, it stays 1 and `sclk_en` stays 0 whatever `xfer_pending` does, until a `soft_rst` pulse or `rst_n` clears the packet count and the flag.
- R6: With `cfg_pkt_limit` = 0 no limit applies, and `limit_done` never rises however many packets complete.
- R7: With `cfg_auto_cs` = 1, a packet start drives `cs_n` to 0 for exactly one cycle with `sclk_en` still 0, and `sclk_en` becomes 1 on the next cycle.
- R8: With `cfg_auto_cs` = 1, a counted `pkt_done` drives `cs_n` to 1 and `sclk_en` to 0 on the next cycle. `cs_n` then stays high for `cfg_gap`+1 cycles before it may fall again.
- R9: With `cfg_auto_cs` = 1, `cfg_manual_cs` has no effect on `cs_n`.
- R10: A `pkt_done` pulse sampled while `sclk_en` is 0 is not counted toward the limit.
- R11: With `cfg_auto_cs` = 1, if `xfer_pending` is 0 when the gap expires, `cs_n` stays high and `sclk_en` stays low until `xfer_pending` returns to 1.
- R12: `soft_rst` has priority over every other input: on the next cycle `sclk_en` is 0, `cs_n` is 1 and `limit_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset pulse that rearms the limit |
| xfer_pending | input | 1 | Transfers are waiting to be shifted |
| pkt_done | input | 1 | One-cycle pulse from the shifter at the last edge of a packet |
| cfg_pkt_limit | input | CNT_W | Number of packets before the clock stops; 0 means unlimited |
| cfg_auto_cs | input | 1 | 1 selects automatic chip-select, 0 selects manual |
| cfg_manual_cs | input | 1 | Chip-select level used in manual mode |
| cfg_gap | input | GAP_W | Inactive chip-select gap between packets, minus one |
| sclk_en | output | 1 | Permission for the serial clock generator to run |
| cs_n | output | 1 | Active-low chip-select |
| limit_done | output | 1 | Sticky flag: packet limit reached |

## Verification
The hardest situations to reach are a packet ending on the exact cycle the gap timer expires, a stray end-of-packet pulse arriving while the clock is stopped, and a limit that falls on a packet which follows a gap. The bench models the shifter. It fires end-of-packet pulses at random while the clock enable is high and, in some phases, spurious pulses while it is low. It sweeps small gap values and small limits with random pending patterns. A cycle-level reference model in the bench predicts all three outputs every cycle. Directed phases add the limit hit, the sticky hold under pending traffic, and the rearm by soft and hardware reset.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SETUP = 2'd1,
        SEQ_RUN   = 2'd2,
        SEQ_GAP   = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       sclk_en;
        logic       cs_n;
    } seq_regs_t;

endpackage

// File: rtl/spi_pkt_limit.sv
module spi_pkt_limit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             count_en,
    input  logic [CNT_W-1:0] limit,
    output logic             hit,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } lim_regs_t;

    lim_regs_t r_q, r_d;
    logic [CNT_W:0] cnt_plus;

    always_comb begin
        r_d      = r_q;
        cnt_plus = {1'b0, r_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        hit      = count_en && (limit != '0) && (cnt_plus >= {1'b0, limit});
        if (clr) begin
            r_d.cnt  = '0;
            r_d.done = 1'b0;
        end else begin
            if (count_en) begin
                r_d.cnt = cnt_plus[CNT_W-1:0];
            end
            if (hit) begin
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done = r_q.done;

    // R5: the done flag only falls through the software reset
    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !clr) |=> r_q.done);

    // R6: a zero limit never raises the flag
    assert_zero_limit_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !hit);

endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int GAP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);

    logic [GAP_W-1:0] gap_q, gap_d;

    always_comb begin
        gap_d = gap_q;
        if (load) begin
            gap_d = load_val;
        end else if (tick && (gap_q != '0)) begin
            gap_d = gap_q - {{(GAP_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_d;
        end
    end

    assign expired = (gap_q == '0);

    // R8: while counting down the timer only moves downward
    assert_gap_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !expired) |=> (gap_q == $past(gap_q) - 1'b1));

endmodule

// File: rtl/spi_pkt_cs_seq.sv
module spi_pkt_cs_seq
    import spi_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int GAP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             xfer_pending,
    input  logic             pkt_done,
    input  logic [CNT_W-1:0] cfg_pkt_limit,
    input  logic             cfg_auto_cs,
    input  logic             cfg_manual_cs,
    input  logic [GAP_W-1:0] cfg_gap,
    output logic             sclk_en,
    output logic             cs_n,
    output logic             limit_done
);

    seq_regs_t r_q, r_d;
    logic      count_en;
    logic      lim_hit;
    logic      lim_done;
    logic      gap_load;
    logic      gap_tick;
    logic      gap_expired;
    logic      may_start;
    logic      past_valid_q;

    assign count_en  = pkt_done && r_q.sclk_en;
    assign may_start = xfer_pending && !lim_done;
    assign gap_tick  = (r_q.st == SEQ_GAP);

    spi_pkt_limit #(
        .CNT_W (CNT_W)
    ) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .count_en (count_en),
        .limit    (cfg_pkt_limit),
        .hit      (lim_hit),
        .done     (lim_done)
    );

    spi_gap_timer #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (cfg_gap),
        .tick     (gap_tick),
        .expired  (gap_expired)
    );

    always_comb begin
        r_d      = r_q;
        gap_load = 1'b0;
        if (soft_rst) begin
            r_d.st      = SEQ_IDLE;
            r_d.sclk_en = 1'b0;
            r_d.cs_n    = 1'b1;
        end else if (!cfg_auto_cs) begin
            r_d.st      = SEQ_IDLE;
            r_d.cs_n    = cfg_manual_cs;
            r_d.sclk_en = may_start && !lim_hit;
        end else begin
            unique case (r_q.st)
                SEQ_IDLE: begin
                    r_d.sclk_en = 1'b0;
                    r_d.cs_n    = 1'b1;
                    if (may_start) begin
                        r_d.st   = SEQ_SETUP;
                        r_d.cs_n = 1'b0;
                    end
                end
                SEQ_SETUP: begin
                    r_d.st      = SEQ_RUN;
                    r_d.sclk_en = 1'b1;
                    r_d.cs_n    = 1'b0;
                end
                SEQ_RUN: begin
                    if (count_en) begin
                        r_d.sclk_en = 1'b0;
                        r_d.cs_n    = 1'b1;
                        if (lim_hit) begin
                            r_d.st = SEQ_IDLE;
                        end else begin
                            r_d.st   = SEQ_GAP;
                            gap_load = 1'b1;
                        end
                    end
                end
                SEQ_GAP: begin
                    r_d.sclk_en = 1'b0;
                    r_d.cs_n    = 1'b1;
                    if (gap_expired) begin
                        if (may_start) begin
                            r_d.st   = SEQ_SETUP;
                            r_d.cs_n = 1'b0;
                        end else begin
                            r_d.st = SEQ_IDLE;
                        end
                    end
                end
                default: begin
                    r_d.st = SEQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= SEQ_IDLE;
            r_q.sclk_en  <= 1'b0;
            r_q.cs_n     <= 1'b1;
            past_valid_q <= 1'b0;
        end else begin
            r_q          <= r_d;
            past_valid_q <= 1'b1;
        end
    end

    assign sclk_en    = r_q.sclk_en;
    assign cs_n       = r_q.cs_n;
    assign limit_done = lim_done;

    // R5: no serial clock once the limit flag is up
    assert_no_clock_after_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        limit_done |-> !sclk_en);

    // R7: in the run phase the select is held low and the clock enabled
    assert_run_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SEQ_RUN) |-> (!cs_n && sclk_en));

    // R8: during the gap the select is released and the clock is off
    assert_gap_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SEQ_GAP) |-> (cs_n && !sclk_en));

    // R2: manual mode copies the software level one cycle later
    assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && $past(!cfg_auto_cs && !soft_rst)) |-> (cs_n == $past(cfg_manual_cs)));

    // R12: software reset returns the outputs to idle
    assert_soft_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!sclk_en && cs_n && !limit_done));

endmodule

// File: tb/spi_pkt_cs_seq_tb.sv
module spi_pkt_cs_seq_tb;

    localparam int CNT_W = 8;
    localparam int GAP_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic             xfer_pending = 1'b0;
    logic             pkt_done = 1'b0;
    logic [CNT_W-1:0] cfg_pkt_limit = '0;
    logic             cfg_auto_cs = 1'b0;
    logic             cfg_manual_cs = 1'b1;
    logic [GAP_W-1:0] cfg_gap = '0;
    logic             sclk_en;
    logic             cs_n;
    logic             limit_done;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    bit    spurious = 1'b0;

    // reference model state
    int m_phase = 0; // 0 idle, 1 setup, 2 run, 3 gap
    int m_gap = 0;
    int m_cnt = 0;
    bit m_done = 0;
    bit m_sclk = 0;
    bit m_cs = 1;

    always #4 clk = ~clk;

    spi_pkt_cs_seq #(
        .CNT_W (CNT_W),
        .GAP_W (GAP_W)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .xfer_pending  (xfer_pending),
        .pkt_done      (pkt_done),
        .cfg_pkt_limit (cfg_pkt_limit),
        .cfg_auto_cs   (cfg_auto_cs),
        .cfg_manual_cs (cfg_manual_cs),
        .cfg_gap       (cfg_gap),
        .sclk_en       (sclk_en),
        .cs_n          (cs_n),
        .limit_done    (limit_done)
    );

    task automatic check_bit(string what, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check_bit("sclk_en", sclk_en, m_sclk);
        check_bit("cs_n", cs_n, m_cs);
        check_bit("limit_done", limit_done, m_done);
    endtask

    // next-state prediction from the requirements, applied for the coming edge
    task automatic model_edge();
        bit cen;
        bit hit;
        cen = pkt_done && m_sclk;
        hit = cen && (cfg_pkt_limit != 0) && ((m_cnt + 1) >= int'(cfg_pkt_limit));
        if (soft_rst) begin                       // R12
            m_phase = 0; m_sclk = 0; m_cs = 1; m_cnt = 0; m_done = 0;
            return;
        end
        if (!cfg_auto_cs) begin                   // R2, R3
            m_phase = 0;
            m_cs    = cfg_manual_cs;
            m_sclk  = xfer_pending && !m_done && !hit;
        end else begin
            case (m_phase)
                0: begin
                    m_sclk = 0; m_cs = 1;
                    if (xfer_pending && !m_done) begin m_phase = 1; m_cs = 0; end
                end
                1: begin m_phase = 2; m_sclk = 1; m_cs = 0; end   // R7
                2: begin
                    if (cen) begin                               // R8
                        m_sclk = 0; m_cs = 1;
                        if (hit) m_phase = 0;
                        else begin m_phase = 3; m_gap = int'(cfg_gap); end
                    end
                end
                default: begin
                    m_sclk = 0; m_cs = 1;
                    if (m_gap == 0) begin                        // R11
                        if (xfer_pending && !m_done) begin m_phase = 1; m_cs = 0; end
                        else m_phase = 0;
                    end else begin
                        m_gap--;
                    end
                end
            endcase
        end
        if (cen) m_cnt = (m_cnt + 1) % (1 << CNT_W);             // R10
        if (hit) m_done = 1;                                     // R4
    endtask

    task automatic step();
        compare_all();
        if (sclk_en) pkt_done = ($urandom % 4 == 0);
        else         pkt_done = spurious && ($urandom % 3 == 0);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        m_phase = 0; m_gap = 0; m_cnt = 0; m_done = 0; m_sclk = 0; m_cs = 1;
        @(negedge clk);
        cur_tag = "R1";
        compare_all();
        @(negedge clk);
        rst_n = 1'b1;
        pkt_done = 1'b0;
    endtask

    task automatic pulse_soft_reset();
        soft_rst = 1'b1;
        pkt_done = 1'b0;
        step();
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        hard_reset();
        cur_tag = "R1";
        step();

        // R2 / R3: manual mode, random level and pending, no limit
        cur_tag = "R2";
        cfg_auto_cs = 1'b0; cfg_pkt_limit = '0;
        for (int i = 0; i < 300; i++) begin
            cfg_manual_cs = 1'($urandom % 2);
            xfer_pending  = ($urandom % 4 != 0);
            if (i == 150) cur_tag = "R3";
            step();
        end

        // R4 then R5: manual mode with a limit of 3 and pending held high
        pulse_soft_reset();
        cur_tag = "R4";
        cfg_pkt_limit = 8'd3; xfer_pending = 1'b1; cfg_manual_cs = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (limit_done) cur_tag = "R5";
            step();
        end
        cur_tag = "R5";
        check_bit("limit_done held", limit_done, 1'b1);
        pulse_soft_reset();
        cur_tag = "R12";
        check_bit("limit_done cleared", limit_done, 1'b0);

        // R9 / R7 / R8: automatic mode, random gap and noise on the manual bit
        cfg_auto_cs = 1'b1; cfg_pkt_limit = '0;
        for (int blk = 0; blk < 6; blk++) begin
            pulse_soft_reset();
            cfg_gap = GAP_W'($urandom % 6);
            cur_tag = (blk % 2 == 0) ? "R9" : "R8";
            for (int i = 0; i < 250; i++) begin
                cfg_manual_cs = 1'($urandom % 2);
                xfer_pending  = ($urandom % 5 != 0);
                if (i == 100) cur_tag = "R7";
                step();
            end
        end

        // R11: pending drops during the gap
        pulse_soft_reset();
        cur_tag = "R11";
        cfg_gap = 10'd4;
        for (int i = 0; i < 300; i++) begin
            xfer_pending = (i % 40 < 12);
            step();
        end

        // R10: stray end-of-packet pulses with a limit in automatic mode
        cur_tag = "R10";
        spurious = 1'b1;
        for (int blk = 0; blk < 8; blk++) begin
            pulse_soft_reset();
            cfg_pkt_limit = CNT_W'(1 + $urandom % 5);
            cfg_gap = GAP_W'($urandom % 4);
            for (int i = 0; i < 200; i++) begin
                xfer_pending = ($urandom % 6 != 0);
                step();
            end
        end

        // R10 in manual mode as well, limit 2
        cfg_auto_cs = 1'b0;
        for (int blk = 0; blk < 4; blk++) begin
            pulse_soft_reset();
            cfg_pkt_limit = 8'd2;
            for (int i = 0; i < 120; i++) begin
                xfer_pending = ($urandom % 3 != 0);
                step();
            end
        end
        spurious = 1'b0;

        // R6: unlimited, long automatic run with zero gap past counter wrap
        cfg_auto_cs = 1'b1; cfg_pkt_limit = '0; cfg_gap = '0;
        pulse_soft_reset();
        cur_tag = "R6";
        xfer_pending = 1'b1;
        for (int i = 0; i < 3000; i++) step();
        check_bit("limit_done unlimited", limit_done, 1'b0);

        // R5: hardware reset rearms the limit after it was hit
        cur_tag = "R5";
        cfg_pkt_limit = 8'd1;
        pulse_soft_reset();
        for (int i = 0; i < 40; i++) step();
        check_bit("limit_done before hw reset", limit_done, 1'b1);
        hard_reset();
        cur_tag = "R1";
        check_bit("sclk_en after hw reset", sclk_en, 1'b0);
        cur_tag = "R5";
        for (int i = 0; i < 40; i++) step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule